// File: doc/BRIEF.md
# Prioritized Restart Interrupt Controller

This block sits beside a small processor's sequencer. It gathers five interrupt sources and, on the cycle the sequencer marks as the next-to-last clock of an instruction, picks the most urgent one that may be taken. The five sources, from most to least urgent, are a nonmaskable trap, three restart lines at levels 7.5, 6.5 and 5.5, and a general request line. A restart pick produces a one-cycle grant carrying a fixed restart address. A pick of the general request produces a one-cycle acknowledge request, so that the sequencer runs an external acknowledge cycle.

The trap must see a rising edge and still be high when it is sampled. It ignores the global enable and the masks. The 7.5 line is edge-latched. The 6.5 and 5.5 lines are level-sensitive. Software loads the three restart masks, the serial output bit and a reset of the 7.5 latch with a set-mask byte. It reads the masks, the global enable, the pending state and the serial input bit back through a read-mask byte. The global enable is raised and lowered by commands. It drops by itself when any maskable source is accepted. Nesting is not tracked: once the enable is raised again, any source may interrupt the handler of a more urgent one.

All pins are plain control and status signals. There is no streamed data path and no back-pressure. The grant and the acknowledge request are single-cycle pulses that the sequencer must take in the cycle they appear.

Top module: `irq_restart_ctrl`

## Requirements
- R1: After reset the three masks read as 1 (all restart lines blocked), the global enable is 0, grant_valid, ack_req and serial_out are 0, and grant_vector is 0.
- R2: When several sources may be taken at once, the pick follows the fixed order trap, then 7.5, then 6.5, then 5.5, then the general request.
- R3: A restart pick raises grant_valid for one cycle, with grant_vector 0x0024 for the trap, 0x003C for 7.5, 0x0034 for 6.5 and 0x002C for 5.5. A general-request pick raises ack_req for one cycle instead, with grant_valid low and grant_vector 0.
- R4: Sources are evaluated only at a clock edge where sample_i is 1. The grant or acknowledge is visible in the cycle that follows that edge, and nothing is issued while sample_i is 0.
- R5: ei_cmd sets the global enable and di_cmd clears it; di_cmd wins if both are given. Accepting any maskable source clears the enable at the same edge. Accepting the trap leaves the enable unchanged. With the enable at 0, no maskable source is taken.
- R6: The trap is taken whatever the enable and the masks hold. It needs a rising edge since its last grant and must still be high at the sample edge. A trap held high after its grant is not taken again, and a trap pulse that has fallen before the sample edge is not taken.
- R7: A rising edge on the 7.5 line is latched and stays pending after the line falls. The latch clears when 7.5 is granted, or when a set-mask byte has bit 4 = 1.
- R8: The 6.5 and 5.5 lines are pending only while they are high at the sample edge. A pulse that has ended is lost.
- R9: A set-mask write with bit 3 = 1 loads the masks from bit 0 (5.5), bit 1 (6.5) and bit 2 (7.5). With bit 3 = 0 the masks keep their values. A restart line whose mask is 1 is never taken.
- R10: A set-mask write with bit 6 = 1 drives serial_out to bit 7 of the byte. With bit 6 = 0 serial_out keeps its value.
- R11: rdmask_data holds the masks in bits 2:0 (5.5, 6.5, 7.5), the global enable in bit 3, the raw 5.5 level in bit 4, the raw 6.5 level in bit 5, the 7.5 latch in bit 6 and serial_in in bit 7. It shows the state present in the current cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_in | input | 1 | Nonmaskable trap request |
| rst75_in | input | 1 | Restart 7.5 request, edge-latched |
| rst65_in | input | 1 | Restart 6.5 request, level |
| rst55_in | input | 1 | Restart 5.5 request, level |
| intr_in | input | 1 | General interrupt request |
| sample_i | input | 1 | Marks the next-to-last clock of an instruction |
| ei_cmd | input | 1 | Enable-interrupts command |
| di_cmd | input | 1 | Disable-interrupts command |
| setmask_we | input | 1 | Set-mask byte write strobe |
| setmask_data | input | 8 | Set-mask byte |
| rdmask_data | output | 8 | Read-mask byte |
| serial_in | input | 1 | Serial input bit |
| serial_out | output | 1 | Serial output bit |
| grant_valid | output | 1 | One-cycle restart grant |
| grant_vector | output | 16 | Restart address that goes with grant_valid |
| ack_req | output | 1 | One-cycle request for an external acknowledge cycle |

## Verification
A grant or acknowledge is due in the cycle after the edge where sample_i is 1, so the bench raises sample_i for exactly one cycle and checks both outputs at the next falling edge. It checks once more one cycle later, to confirm the pulse is gone. Set-mask writes, enable commands and edge latching each take effect at one rising edge. The bench therefore waits at least one full cycle before it reads rdmask_data, and it holds the request lines for two cycles before sampling. Level lines and serial_in appear in rdmask_data in the same cycle, and they are read at the falling edge after they are driven.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 5;
  localparam int NRST = 3;
  typedef enum logic [2:0] {
    SRC_TRAP = 3'd0,
    SRC_R75  = 3'd1,
    SRC_R65  = 3'd2,
    SRC_R55  = 3'd3,
    SRC_INTR = 3'd4
  } src_e;
  // set-mask byte fields
  localparam int SM_MSE  = 3;
  localparam int SM_CLR75 = 4;
  localparam int SM_SOE  = 6;
  localparam int SM_SOD  = 7;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] held_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_lat
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q[g] <= 1'b0;
        held_o[g] <= 1'b0;
      end else begin
        prev_q[g] <= lvl_i[g];
        // a new edge wins over a clear in the same cycle
        held_o[g] <= (held_o[g] & ~clr_i[g]) | (lvl_i[g] & ~prev_q[g]);
      end
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             accept_i,
  input  logic             we_i,
  input  logic [CMD_W-1:0] data_i,
  output logic [NRST-1:0]  mask_o,
  output logic             ie_o,
  output logic             sod_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_o <= '1;
      ie_o   <= 1'b0;
      sod_o  <= 1'b0;
    end else begin
      if (we_i && data_i[SM_MSE]) mask_o <= data_i[NRST-1:0];
      if (we_i && data_i[SM_SOE]) sod_o <= data_i[SM_SOD];
      if (accept_i)   ie_o <= 1'b0;
      else if (di_i)  ie_o <= 1'b0;
      else if (ei_i)  ie_o <= 1'b1;
    end
  end

  AST_ACCEPT_DROPS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> !ie_o); // R5
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] pick_o,
  output logic         any_o
);
  // index 0 is the most urgent
  always_comb begin
    pick_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) pick_o = N'(1) << i;
    end
  end
  assign any_o = |req_i;

  always_comb begin
    AST_PICK_ONEHOT: assert ($onehot0(pick_o)); // R2
    AST_PICK_IN_REQ: assert ((pick_o & ~req_i) == '0); // R2
  end
endmodule

// File: rtl/irq_restart_ctrl.sv
module irq_restart_ctrl
  import irq_pkg::*;
#(
  parameter int          VEC_W    = 16,
  parameter int          CMD_W    = 8,
  parameter logic [15:0] VEC_TRAP = 16'h0024,
  parameter logic [15:0] VEC_R75  = 16'h003C,
  parameter logic [15:0] VEC_R65  = 16'h0034,
  parameter logic [15:0] VEC_R55  = 16'h002C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_in,
  input  logic             rst75_in,
  input  logic             rst65_in,
  input  logic             rst55_in,
  input  logic             intr_in,
  input  logic             sample_i,
  input  logic             ei_cmd,
  input  logic             di_cmd,
  input  logic             setmask_we,
  input  logic [CMD_W-1:0] setmask_data,
  output logic [CMD_W-1:0] rdmask_data,
  input  logic             serial_in,
  output logic             serial_out,
  output logic             grant_valid,
  output logic [VEC_W-1:0] grant_vector,
  output logic             ack_req
);
  localparam int NEDGE = 2; // 0: trap, 1: restart 7.5

  logic [NRST-1:0]  mask;
  logic             ie;
  logic [NEDGE-1:0] edge_held, edge_clr;
  logic [NSRC-1:0]  req, pick;
  logic             any, take, accept_maskable;
  logic [VEC_W-1:0] vec_sel;
  logic             unused_sm_bit;

  assign unused_sm_bit = setmask_data[5];

  irq_edge_latch #(.N(NEDGE)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i ({rst75_in, trap_in}),
    .clr_i (edge_clr),
    .held_o(edge_held)
  );

  irq_mask_reg #(.CMD_W(CMD_W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .ei_i    (ei_cmd),
    .di_i    (di_cmd),
    .accept_i(accept_maskable),
    .we_i    (setmask_we),
    .data_i  (setmask_data),
    .mask_o  (mask),
    .ie_o    (ie),
    .sod_o   (serial_out)
  );

  always_comb begin
    req           = '0;
    req[SRC_TRAP] = edge_held[0] & trap_in;
    req[SRC_R75]  = ie & ~mask[2] & edge_held[1];
    req[SRC_R65]  = ie & ~mask[1] & rst65_in;
    req[SRC_R55]  = ie & ~mask[0] & rst55_in;
    req[SRC_INTR] = ie & intr_in;
  end

  irq_prio_pick #(.N(NSRC)) u_pick (
    .req_i (req),
    .pick_o(pick),
    .any_o (any)
  );

  assign take            = sample_i & any;
  assign accept_maskable = take & ~pick[SRC_TRAP];
  assign edge_clr[0]     = take & pick[SRC_TRAP];
  assign edge_clr[1]     = (take & pick[SRC_R75]) | (setmask_we & setmask_data[SM_CLR75]);

  always_comb begin
    vec_sel = '0;
    if (pick[SRC_TRAP])     vec_sel = VEC_W'(VEC_TRAP);
    else if (pick[SRC_R75]) vec_sel = VEC_W'(VEC_R75);
    else if (pick[SRC_R65]) vec_sel = VEC_W'(VEC_R65);
    else if (pick[SRC_R55]) vec_sel = VEC_W'(VEC_R55);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_valid  <= 1'b0;
      grant_vector <= '0;
      ack_req      <= 1'b0;
    end else begin
      grant_valid  <= take & ~pick[SRC_INTR];
      ack_req      <= take & pick[SRC_INTR];
      grant_vector <= (take & ~pick[SRC_INTR]) ? vec_sel : '0;
    end
  end

  assign rdmask_data = CMD_W'({serial_in, edge_held[1], rst65_in, rst55_in, ie, mask});

  AST_GRANT_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_valid && ack_req)); // R3
  AST_ONLY_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid || ack_req) |-> $past(sample_i)); // R4
  AST_MASKABLE_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_valid && grant_vector != VEC_W'(VEC_TRAP)) || ack_req) |-> !ie); // R5
  AST_TRAP_STILL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && grant_vector == VEC_W'(VEC_TRAP)) |-> $past(trap_in)); // R6
  AST_MASKED_55_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && grant_vector == VEC_W'(VEC_R55)) |-> !$past(mask[0])); // R9
endmodule

// File: tb/sim_irq_restart_ctrl.sv
`timescale 1ns/1ps
module sim_irq_restart_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_in = 0, rst75_in = 0, rst65_in = 0, rst55_in = 0, intr_in = 0;
  logic sample_i = 0, ei_cmd = 0, di_cmd = 0, setmask_we = 0, serial_in = 0;
  logic [7:0] setmask_data = '0;
  logic [7:0] rdmask_data;
  logic serial_out, grant_valid, ack_req;
  logic [15:0] grant_vector;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_restart_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .trap_in(trap_in), .rst75_in(rst75_in),
    .rst65_in(rst65_in), .rst55_in(rst55_in), .intr_in(intr_in),
    .sample_i(sample_i), .ei_cmd(ei_cmd), .di_cmd(di_cmd),
    .setmask_we(setmask_we), .setmask_data(setmask_data),
    .rdmask_data(rdmask_data), .serial_in(serial_in), .serial_out(serial_out),
    .grant_valid(grant_valid), .grant_vector(grant_vector), .ack_req(ack_req)
  );

  // fields: [18] ie, [17:15] masks {7.5,6.5,5.5}, [14:10] {trap,7.5,6.5,5.5,intr},
  //         [9] grant, [8] ack, [7:0] vector low byte
  localparam logic [18:0] TBL [10] = '{
    {1'b1, 3'b000, 5'b11111, 1'b1, 1'b0, 8'h24}, // R2 trap on top
    {1'b1, 3'b000, 5'b01111, 1'b1, 1'b0, 8'h3C}, // R2 7.5 next
    {1'b1, 3'b000, 5'b00111, 1'b1, 1'b0, 8'h34}, // R2 6.5
    {1'b1, 3'b000, 5'b00011, 1'b1, 1'b0, 8'h2C}, // R2 5.5
    {1'b1, 3'b000, 5'b00001, 1'b0, 1'b1, 8'h00}, // R3 general request
    {1'b0, 3'b000, 5'b01111, 1'b0, 1'b0, 8'h00}, // R5 enable off
    {1'b0, 3'b111, 5'b10000, 1'b1, 1'b0, 8'h24}, // R6 trap ignores all
    {1'b1, 3'b100, 5'b01100, 1'b1, 1'b0, 8'h34}, // R9 7.5 masked
    {1'b1, 3'b011, 5'b00111, 1'b0, 1'b1, 8'h00}, // R9 6.5/5.5 masked
    {1'b1, 3'b111, 5'b01110, 1'b0, 1'b0, 8'h00}  // R9 all restarts masked
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_mask(input logic [7:0] b);
    setmask_we = 1; setmask_data = b;
    tick(1);
    setmask_we = 0; setmask_data = '0;
  endtask

  task automatic set_ie(input logic en);
    ei_cmd = en; di_cmd = !en;
    tick(1);
    ei_cmd = 0; di_cmd = 0;
  endtask

  task automatic strobe();
    sample_i = 1;
    tick(1);
    sample_i = 0;
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state, R11 layout
    chk("R1 grant", {31'b0, grant_valid}, 0);
    chk("R1 ack", {31'b0, ack_req}, 0);
    chk("R1 vector", {16'b0, grant_vector}, 0);
    chk("R1 serial_out", {31'b0, serial_out}, 0);
    chk("R1 rdmask", {24'b0, rdmask_data}, 32'h07);

    // table walk: R2 R3 R5 R6 R9
    for (int i = 0; i < 10; i++) begin
      logic [18:0] e;
      e = TBL[i];
      setmask_we = 1; setmask_data = {3'b000, 1'b1, 1'b1, e[17:15]};
      ei_cmd = e[18]; di_cmd = !e[18];
      tick(1);
      setmask_we = 0; setmask_data = '0; ei_cmd = 0; di_cmd = 0;
      {trap_in, rst75_in, rst65_in, rst55_in, intr_in} = e[14:10];
      tick(2);
      strobe();
      chk($sformatf("R2 R3 row%0d grant", i), {31'b0, grant_valid}, {31'b0, e[9]});
      chk($sformatf("R3 row%0d ack", i), {31'b0, ack_req}, {31'b0, e[8]});
      chk($sformatf("R3 row%0d vector", i), {16'b0, grant_vector}, {24'b0, e[7:0]});
      tick(1);
      chk($sformatf("R4 row%0d pulse ends", i), {30'b0, grant_valid, ack_req}, 0);
      {trap_in, rst75_in, rst65_in, rst55_in, intr_in} = '0;
      tick(2);
    end

    // R4: no issue without strobe, then issue one cycle after it
    write_mask(8'h18); set_ie(1);
    rst55_in = 1;
    tick(5);
    chk("R4 no strobe", {30'b0, grant_valid, ack_req}, 0);
    strobe();
    chk("R4 grant after strobe", {15'b0, grant_valid, grant_vector}, {15'b0, 1'b1, 16'h002C});
    chk("R5 ie cleared by accept", {31'b0, rdmask_data[3]}, 0);
    rst55_in = 0;
    tick(1);

    // R5: ei/di commands and di precedence
    set_ie(1);
    chk("R5 ei sets", {31'b0, rdmask_data[3]}, 1);
    ei_cmd = 1; di_cmd = 1; tick(1); ei_cmd = 0; di_cmd = 0;
    chk("R5 di wins", {31'b0, rdmask_data[3]}, 0);

    // R6: trap keeps ie; trap held high is not retaken; fallen pulse lost
    set_ie(1);
    trap_in = 1; tick(2); strobe();
    chk("R6 trap grant", {15'b0, grant_valid, grant_vector}, {15'b0, 1'b1, 16'h0024});
    chk("R5 trap keeps ie", {31'b0, rdmask_data[3]}, 1);
    tick(1); strobe();
    chk("R6 trap held not retaken", {31'b0, grant_valid}, 0);
    trap_in = 0; tick(2);
    trap_in = 1; tick(1); trap_in = 0; tick(2); strobe();
    chk("R6 fallen trap lost", {31'b0, grant_valid}, 0);

    // R7: 7.5 pulse is latched, then cleared by grant
    write_mask(8'h18); set_ie(1);
    rst75_in = 1; tick(1); rst75_in = 0; tick(2);
    chk("R7 latch visible", {31'b0, rdmask_data[6]}, 1);
    strobe();
    chk("R7 latched grant", {15'b0, grant_valid, grant_vector}, {15'b0, 1'b1, 16'h003C});
    chk("R7 latch cleared by grant", {31'b0, rdmask_data[6]}, 0);
    // R7: cleared by set-mask bit 4
    set_ie(1);
    rst75_in = 1; tick(1); rst75_in = 0; tick(1);
    write_mask(8'h10);
    chk("R7 latch cleared by write", {31'b0, rdmask_data[6]}, 0);
    strobe();
    chk("R7 no grant after clear", {31'b0, grant_valid}, 0);

    // R8: level lines
    rst65_in = 1; tick(1);
    chk("R8 6.5 level shown", {31'b0, rdmask_data[5]}, 1);
    rst65_in = 0; tick(1);
    chk("R8 6.5 level gone", {31'b0, rdmask_data[5]}, 0);
    strobe();
    chk("R8 ended pulse lost", {31'b0, grant_valid}, 0);

    // R9: bit 3 = 0 keeps masks
    write_mask(8'h0D);
    chk("R9 masks loaded", {29'b0, rdmask_data[2:0]}, 5);
    write_mask(8'h02);
    chk("R9 masks kept", {29'b0, rdmask_data[2:0]}, 5);

    // R10: serial output
    write_mask(8'hC0);
    chk("R10 serial_out set", {31'b0, serial_out}, 1);
    write_mask(8'h80);
    chk("R10 serial_out kept", {31'b0, serial_out}, 1);
    write_mask(8'h40);
    chk("R10 serial_out cleared", {31'b0, serial_out}, 0);

    // R11: serial input bit
    serial_in = 1; tick(1);
    chk("R11 serial_in bit7", {31'b0, rdmask_data[7]}, 1);
    serial_in = 0; tick(1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule